// File: doc/BRIEF.md
# Mailbox Command Sequencer

This engine runs one complete request/reply exchange with a coprocessor that listens on two 32-bit mailbox registers and shares a 16-word message RAM. A one-cycle start pulse picks a command index. The engine looks the index up in a small built-in template table, whose contents depend on the API version parameter. It waits until the host-bound mailbox reads zero, then writes all 16 message words with a checksum placed after the last argument, and rings the doorbell. Next it polls for a non-zero response code, reads back all 16 reply words and releases the mailbox. Last, it checks the reply checksum and reports a status word alongside the reply.

All traffic goes over a simple single-master register bus. The engine raises a request with address, direction and write data, and holds all of them until the slave acknowledges. A read returns its data in the acknowledge cycle. Between two failed polls the engine idles for a number of cycles set by the `poll_gap` input.

Top module: `mbox_cmd_seq`

## Requirements
- R1: `busy` goes high in the cycle after a start is accepted in idle and stays high up to and including the single cycle in which `done` is high. A start that arrives while `busy` is high is ignored and gives no extra `done`.
- R2: An index that has no template returns status 0x80000002 with `done` high in the cycle right after the start, and makes no bus transfer. With API version 3 the valid indices are 0 and 1. With API version 1 they are 0, 1 and 2. Index 3 is never valid.
- R3: Before sending, the engine reads address 0x014 until it returns zero, with at least `poll_gap` idle cycles between reads. If 1000 reads (MAX_POLLS) all return non-zero, the status is 0x80000010 (bit 31 plus bit 4) and nothing is written.
- R4: The 16 message words are written in ascending order to 0x100+4*i. Word 0 is the header (1), word 1 the command code, word 2 the argument count N, and word 3 onward the arguments; unused slots are zero. Slot N+3 instead holds the 32-bit wrapping sum of words 0..N+2. Templates as (code, N, arg): API 3 index 0 = (0x101, 1, 1), index 1 = (0x202, 0, -). API 1 index 0 = (1, 1, 1), index 1 = (2, 1, 1), index 2 = (2, 1, 2).
- R5: After the 16th message word the engine writes the value 1 to 0x010, exactly once.
- R6: After the doorbell the engine reads 0x014 until it returns non-zero, for at most MAX_POLLS reads. It then reads all 16 message words, and `reply` shows them when `done` is high. `reply` is all zero after a timeout.
- R7: After the reply is read, or after a response timeout (status 0x80000010), the engine writes 0 to the release mailbox as its last write. This is 0x014 for API version below 2 and 0x010 otherwise.
- R8: The reply checksum sits at word M+3, where M is reply word 2. If it differs from the wrapping sum of reply words 0..M+2, or if M > 12, the status is 0x80000004.
- R9: When the reply checksum matches, the status equals the response code that was read from 0x014: 1 means success, and any other value is passed on as an error.
- R10: Once `bus_req` is raised, it stays high with stable address, direction and write data until the cycle in which `bus_ack` is high. `bus_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled in idle only |
| cmd_idx | input | IDX_W | Template index for the command |
| poll_gap | input | GAP_W | Idle cycles after a failed poll |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Result code, valid with done |
| reply | output | 16x32 | Reply words, valid with done |

## Verification
A wrong checksum accumulator shows up as a wrong word in the message-RAM image the bus model captures, or as a false checksum status on a good reply. Both are seen as soon as `done` pulses, within a few hundred cycles of the start. A poll counter that miscounts shows up as the wrong number of mailbox reads before the timeout status. A wrong release decision shows up in the address of the final bus write. The bench sweeps every index, several reply argument counts (including the out-of-range count) and several response codes on two API variants. It compares every written and read word against values computed from the template table.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MSG_WORDS = 16;
    localparam int ADDR_W    = 12;

    localparam logic [ADDR_W-1:0] A_TO_CP   = 12'h010;
    localparam logic [ADDR_W-1:0] A_TO_HOST = 12'h014;
    localparam logic [ADDR_W-1:0] A_MSG     = 12'h100;

    localparam logic [31:0] ST_ERR_BIT = 32'h8000_0000;
    localparam logic [31:0] ST_INVAL   = ST_ERR_BIT | 32'h2;
    localparam logic [31:0] ST_CHKSUM  = ST_ERR_BIT | 32'h4;
    localparam logic [31:0] ST_TIMEOUT = ST_ERR_BIT | 32'h10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IDLE_RD,
        S_IDLE_GAP,
        S_WR_MSG,
        S_BELL,
        S_RESP_RD,
        S_RESP_GAP,
        S_RD_MSG,
        S_REL,
        S_CHECK,
        S_REPORT
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
    } bus_cmd_t;

    function automatic logic [ADDR_W-1:0] msg_addr(input logic [3:0] i);
        return A_MSG + {6'b0, i, 2'b00};
    endfunction

endpackage

// File: rtl/mbox_template.sv
module mbox_template #(
    parameter int API_VER = 3,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic              valid,
    output logic [3:0][31:0]  head
);

    generate
        if (API_VER < 2) begin : g_old
            always_comb begin
                valid = 1'b1;
                head  = '0;
                case (idx)
                    IDX_W'(0): head = {32'd1, 32'd1, 32'd1, 32'd1};
                    IDX_W'(1): head = {32'd1, 32'd1, 32'd2, 32'd1};
                    IDX_W'(2): head = {32'd2, 32'd1, 32'd2, 32'd1};
                    default:   valid = 1'b0;
                endcase
            end
        end else if (API_VER == 2) begin : g_mid
            always_comb begin
                valid = 1'b1;
                head  = '0;
                case (idx)
                    IDX_W'(0): head = {32'd0, 32'd0, 32'h101, 32'd1};
                    IDX_W'(1): head = {32'd0, 32'd0, 32'h201, 32'd1};
                    IDX_W'(2): head = {32'd0, 32'd0, 32'h202, 32'd1};
                    default:   valid = 1'b0;
                endcase
            end
        end else begin : g_new
            always_comb begin
                valid = 1'b1;
                head  = '0;
                case (idx)
                    IDX_W'(0): head = {32'd1, 32'd1, 32'h101, 32'd1};
                    IDX_W'(1): head = {32'd0, 32'd0, 32'h202, 32'd1};
                    default:   valid = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/mbox_poll.sv
module mbox_poll #(
    parameter int MAX_POLLS = 1000,
    parameter int GAP_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             miss,
    input  logic [GAP_W-1:0] gap_len,
    output logic             last_try,
    output logic             gap_done
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] tries;
    logic [GAP_W-1:0] gap;

    assign last_try = (tries == CNT_W'(MAX_POLLS - 1));
    assign gap_done = (gap == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries <= '0;
        end else if (miss) begin
            tries <= tries + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (miss) begin
            gap <= gap_len;
        end else if (gap != '0) begin
            gap <= gap - 1'b1;
        end
    end

endmodule

// File: rtl/mbox_sum.sv
module mbox_sum (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        add,
    input  logic [31:0] din,
    output logic [31:0] sum
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + din;
        end
    end

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter int API_VER   = 3,
    parameter int MAX_POLLS = 1000,
    parameter int GAP_W     = 16,
    parameter int IDX_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [IDX_W-1:0]               cmd_idx,
    input  logic [GAP_W-1:0]               poll_gap,
    output logic                           bus_req,
    output logic                           bus_we,
    output logic [ADDR_W-1:0]              bus_addr,
    output logic [31:0]                    bus_wdata,
    input  logic                           bus_ack,
    input  logic [31:0]                    bus_rdata,
    output logic                           busy,
    output logic                           done,
    output logic [31:0]                    status,
    output logic [MSG_WORDS-1:0][31:0]     reply
);

    localparam logic [ADDR_W-1:0] REL_ADDR = (API_VER < 2) ? A_TO_HOST : A_TO_CP;

    seq_state_e       state;
    logic [3:0]       word_i;
    logic [3:0][31:0] head_q;
    logic [31:0]      rx_n;
    logic [31:0]      resp;
    logic [31:0]      rx_ck;
    logic             ck_seen;
    logic             timed_out;

    logic             tmpl_valid;
    logic [3:0][31:0] tmpl_head;
    logic             xfer, is_poll, poll_hit, miss, poll_clr;
    logic             last_try, gap_done;
    logic             sum_clr, sum_add;
    logic [31:0]      sum_din, sum_q;
    logic [31:0]      tx_word;
    logic             issue;
    bus_cmd_t         nx;
    logic [32:0]      word_x;
    logic             tx_in_sum, rx_in_sum, rx_is_ck;

    mbox_template #(.API_VER(API_VER), .IDX_W(IDX_W)) u_tmpl (
        .idx   (cmd_idx),
        .valid (tmpl_valid),
        .head  (tmpl_head)
    );

    assign xfer     = bus_req && bus_ack;
    assign is_poll  = (state == S_IDLE_RD) || (state == S_RESP_RD);
    assign poll_hit = xfer && is_poll &&
                      ((state == S_IDLE_RD) ? (bus_rdata == '0) : (bus_rdata != '0));
    assign miss     = xfer && is_poll && !poll_hit;
    assign poll_clr = ((state == S_IDLE) && start) || ((state == S_BELL) && xfer);

    mbox_poll #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .clr      (poll_clr),
        .miss     (miss),
        .gap_len  (poll_gap),
        .last_try (last_try),
        .gap_done (gap_done)
    );

    assign word_x    = {29'b0, word_i};
    assign tx_in_sum = word_x <= ({1'b0, head_q[2]} + 33'd2);
    assign rx_in_sum = (word_i <= 4'd2) || (word_x <= ({1'b0, rx_n} + 33'd2));
    assign rx_is_ck  = (word_i >= 4'd3) && (word_x == ({1'b0, rx_n} + 33'd3));

    assign sum_clr = poll_hit;
    assign sum_add = xfer && (((state == S_WR_MSG) && tx_in_sum) ||
                              ((state == S_RD_MSG) && rx_in_sum));
    assign sum_din = (state == S_RD_MSG) ? bus_rdata : bus_wdata;

    mbox_sum u_sum (
        .clk (clk),
        .rst (rst),
        .clr (sum_clr),
        .add (sum_add),
        .din (sum_din),
        .sum (sum_q)
    );

    always_comb begin
        tx_word = (word_i < 4'd4) ? head_q[word_i[1:0]] : 32'd0;
        if (word_x == ({1'b0, head_q[2]} + 33'd3)) begin
            tx_word = sum_q;
        end
    end

    always_comb begin
        nx = '{we: 1'b0, addr: A_TO_HOST, wdata: 32'd0};
        unique case (state)
            S_WR_MSG: nx = '{we: 1'b1, addr: msg_addr(word_i), wdata: tx_word};
            S_BELL:   nx = '{we: 1'b1, addr: A_TO_CP, wdata: 32'd1};
            S_RD_MSG: nx = '{we: 1'b0, addr: msg_addr(word_i), wdata: 32'd0};
            S_REL:    nx = '{we: 1'b1, addr: REL_ADDR, wdata: 32'd0};
            default:  nx = '{we: 1'b0, addr: A_TO_HOST, wdata: 32'd0};
        endcase
    end

    assign issue = (state == S_IDLE_RD) || (state == S_WR_MSG) || (state == S_BELL) ||
                   (state == S_RESP_RD) || (state == S_RD_MSG) || (state == S_REL);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (xfer) begin
            bus_req <= 1'b0;
        end else if (!bus_req && issue) begin
            bus_req   <= 1'b1;
            bus_we    <= nx.we;
            bus_addr  <= nx.addr;
            bus_wdata <= nx.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            word_i    <= '0;
            head_q    <= '0;
            rx_n      <= '0;
            resp      <= '0;
            rx_ck     <= '0;
            ck_seen   <= 1'b0;
            timed_out <= 1'b0;
            status    <= '0;
            reply     <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        reply     <= '0;
                        rx_n      <= '0;
                        ck_seen   <= 1'b0;
                        timed_out <= 1'b0;
                        head_q    <= tmpl_head;
                        if (tmpl_valid) begin
                            state <= S_IDLE_RD;
                        end else begin
                            status <= ST_INVAL;
                            state  <= S_REPORT;
                        end
                    end
                end
                S_IDLE_RD: begin
                    if (poll_hit) begin
                        word_i <= '0;
                        state  <= S_WR_MSG;
                    end else if (miss && last_try) begin
                        status <= ST_TIMEOUT;
                        state  <= S_REPORT;
                    end else if (miss) begin
                        state <= S_IDLE_GAP;
                    end
                end
                S_IDLE_GAP: begin
                    if (gap_done) state <= S_IDLE_RD;
                end
                S_WR_MSG: begin
                    if (xfer) begin
                        if (word_i == 4'd15) state <= S_BELL;
                        word_i <= word_i + 1'b1;
                    end
                end
                S_BELL: begin
                    if (xfer) state <= S_RESP_RD;
                end
                S_RESP_RD: begin
                    if (poll_hit) begin
                        resp   <= bus_rdata;
                        word_i <= '0;
                        state  <= S_RD_MSG;
                    end else if (miss && last_try) begin
                        status    <= ST_TIMEOUT;
                        timed_out <= 1'b1;
                        state     <= S_REL;
                    end else if (miss) begin
                        state <= S_RESP_GAP;
                    end
                end
                S_RESP_GAP: begin
                    if (gap_done) state <= S_RESP_RD;
                end
                S_RD_MSG: begin
                    if (xfer) begin
                        reply[word_i] <= bus_rdata;
                        if (word_i == 4'd2) rx_n <= bus_rdata;
                        if (rx_is_ck) begin
                            rx_ck   <= bus_rdata;
                            ck_seen <= 1'b1;
                        end
                        if (word_i == 4'd15) state <= S_REL;
                        word_i <= word_i + 1'b1;
                    end
                end
                S_REL: begin
                    if (xfer) state <= timed_out ? S_REPORT : S_CHECK;
                end
                S_CHECK: begin
                    if (!ck_seen || (sum_q != rx_ck)) begin
                        status <= ST_CHKSUM;
                    end else begin
                        status <= resp;
                    end
                    state <= S_REPORT;
                end
                S_REPORT: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_REPORT);

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    // R1
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R1
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

    // R7
    host_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == A_TO_HOST) |-> bus_wdata == 32'd0);

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_model (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              req,
    input  logic              we,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic [31:0]       rdata,
    input  int                busy_reads,
    input  int                resp_lat,
    input  logic [31:0]       resp_code,
    input  int                rep_n,
    input  logic              corrupt,
    output int                wr_cnt,
    output int                host_rd,
    output int                bell_cnt,
    output int                gap_min,
    output int                gap_max,
    output logic [11:0]       last_addr,
    output logic [31:0]       last_data,
    output logic [15:0][31:0] txmsg
);

    int   pre_cnt, post_cnt, since;
    logic bell, prev_host;

    function automatic logic [31:0] base_word(int j, logic [31:0] c1, int n);
        if (j == 0) return 32'd2;
        if (j == 1) return c1;
        if (j == 2) return n;
        if (j < n + 3) return 32'h0A00_0000 + j;
        return 32'd0;
    endfunction

    function automatic logic [31:0] rep_word(int i, logic [31:0] c1, int n, logic cor);
        logic [31:0] s = 0;
        if (n <= 12 && i == n + 3) begin
            for (int j = 0; j < n + 3; j++) s += base_word(j, c1, n);
            return s + {31'b0, cor};
        end
        return base_word(i, c1, n);
    endfunction

    wire is_msg = (addr >= 12'h100) && (addr < 12'h140);

    always_comb begin
        rdata = 32'd0;
        if (addr == 12'h014) begin
            if (!bell) rdata = (pre_cnt < busy_reads) ? 32'hBAD0_0001 : 32'd0;
            else       rdata = (post_cnt >= resp_lat) ? resp_code : 32'd0;
        end else if (is_msg) begin
            rdata = bell ? rep_word(int'(addr[5:2]), txmsg[1], rep_n, corrupt) : txmsg[addr[5:2]];
        end
    end

    always @(posedge clk) begin
        if (rst || clear) begin
            ack <= 0; pre_cnt <= 0; post_cnt <= 0; since <= 0; bell <= 0; prev_host <= 0;
            wr_cnt <= 0; host_rd <= 0; bell_cnt <= 0; gap_min <= 1000000; gap_max <= 0;
            last_addr <= 0; last_data <= 32'hFFFF_FFFF; txmsg <= '0;
        end else begin
            ack   <= req && !ack;
            since <= since + 1;
            if (req && ack) begin
                prev_host <= 0;
                if (we) begin
                    wr_cnt    <= wr_cnt + 1;
                    last_addr <= addr;
                    last_data <= wdata;
                    if (is_msg) txmsg[addr[5:2]] <= wdata;
                    if (addr == 12'h010 && wdata == 32'd1) begin
                        bell <= 1; bell_cnt <= bell_cnt + 1;
                    end
                end else if (addr == 12'h014) begin
                    host_rd   <= host_rd + 1;
                    prev_host <= 1;
                    since     <= 0;
                    if (prev_host) begin
                        if (since < gap_min) gap_min <= since;
                        if (since > gap_max) gap_max <= since;
                    end
                    if (!bell) pre_cnt <= pre_cnt + 1;
                    else       post_cnt <= post_cnt + 1;
                end
            end
        end
    end

endmodule

module mbox_cmd_seq_bench;

    localparam int GAP = 2;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic              start [2];
    logic [1:0]        idx   [2];
    logic              req [2], we [2], ack [2], busy [2], done [2], clear [2];
    logic [11:0]       addr [2];
    logic [31:0]       wdata [2], rdata [2], status [2];
    logic [15:0][31:0] reply [2];
    logic [15:0][31:0] txmsg [2];
    int                busy_reads [2], resp_lat [2], rep_n [2];
    logic [31:0]       resp_code [2];
    logic              corrupt [2];
    int                wr_cnt [2], host_rd [2], bell_cnt [2], gap_min [2], gap_max [2];
    logic [11:0]       last_addr [2];
    logic [31:0]       last_data [2];
    int                done_cnt [2];

    int errors = 0;
    int checks = 0;

    mbox_cmd_seq #(.API_VER(3)) u_mbox_cmd_seq (
        .clk(clk), .rst(rst), .start(start[0]), .cmd_idx(idx[0]), .poll_gap(16'(GAP)),
        .bus_req(req[0]), .bus_we(we[0]), .bus_addr(addr[0]), .bus_wdata(wdata[0]),
        .bus_ack(ack[0]), .bus_rdata(rdata[0]), .busy(busy[0]), .done(done[0]),
        .status(status[0]), .reply(reply[0]));

    mbox_cmd_seq #(.API_VER(1)) u_mbox_cmd_seq_v1 (
        .clk(clk), .rst(rst), .start(start[1]), .cmd_idx(idx[1]), .poll_gap(16'(GAP)),
        .bus_req(req[1]), .bus_we(we[1]), .bus_addr(addr[1]), .bus_wdata(wdata[1]),
        .bus_ack(ack[1]), .bus_rdata(rdata[1]), .busy(busy[1]), .done(done[1]),
        .status(status[1]), .reply(reply[1]));

    for (genvar g = 0; g < 2; g++) begin : g_model
        mbox_model u_model (
            .clk(clk), .rst(rst), .clear(clear[g]), .req(req[g]), .we(we[g]), .addr(addr[g]),
            .wdata(wdata[g]), .ack(ack[g]), .rdata(rdata[g]), .busy_reads(busy_reads[g]),
            .resp_lat(resp_lat[g]), .resp_code(resp_code[g]), .rep_n(rep_n[g]),
            .corrupt(corrupt[g]), .wr_cnt(wr_cnt[g]), .host_rd(host_rd[g]),
            .bell_cnt(bell_cnt[g]), .gap_min(gap_min[g]), .gap_max(gap_max[g]),
            .last_addr(last_addr[g]), .last_data(last_data[g]), .txmsg(txmsg[g]));
        always @(posedge clk) if (!rst && done[g]) done_cnt[g] <= done_cnt[g] + 1;
    end

    function automatic bit t_valid(int api, int i);
        return (api >= 3) ? (i < 2) : (i < 3);
    endfunction

    function automatic logic [31:0] t_head(int api, int i, int w);
        logic [31:0] h [4];
        if (api >= 3) begin
            if (i == 0) h = '{1, 32'h101, 1, 1};
            else        h = '{1, 32'h202, 0, 0};
        end else begin
            if (i == 0)      h = '{1, 1, 1, 1};
            else if (i == 1) h = '{1, 2, 1, 1};
            else             h = '{1, 2, 1, 2};
        end
        return (w < 4) ? h[w] : 32'd0;
    endfunction

    function automatic logic [31:0] exp_tx(int api, int i, int w);
        int n = int'(t_head(api, i, 2));
        logic [31:0] s = 0;
        if (w == n + 3) begin
            for (int j = 0; j < n + 3; j++) s += t_head(api, i, j);
            return s;
        end
        return t_head(api, i, w);
    endfunction

    function automatic logic [31:0] exp_base(int j, logic [31:0] c1, int n);
        if (j == 0) return 32'd2;
        if (j == 1) return c1;
        if (j == 2) return n;
        if (j < n + 3) return 32'h0A00_0000 + j;
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_rep(int i, logic [31:0] c1, int n, logic cor);
        logic [31:0] s = 0;
        if (n <= 12 && i == n + 3) begin
            for (int j = 0; j < n + 3; j++) s += exp_base(j, c1, n);
            return s + {31'b0, cor};
        end
        return exp_base(i, c1, n);
    endfunction

    task automatic chk(bit ok, string req_tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic run(int w, int i, int br, int rl, logic [31:0] code, int n, bit cor, bit poke);
        int api = (w == 0) ? 3 : 1;
        int d0, k;
        logic [31:0] exp_st;
        logic [11:0] rel = (api < 2) ? 12'h014 : 12'h010;
        bit idle_to, resp_to, bad;
        busy_reads[w] = br; resp_lat[w] = rl; resp_code[w] = code; rep_n[w] = n; corrupt[w] = cor;
        clear[w] = 1; @(negedge clk); clear[w] = 0;
        d0 = done_cnt[w];
        idx[w] = 2'(i); start[w] = 1; @(negedge clk); start[w] = 0;
        // R1: busy in the cycle after start
        chk(busy[w] === 1'b1, "R1 busy", {31'b0, busy[w]}, 1);
        if (!t_valid(api, i)) begin
            // R2: immediate invalid status
            chk(done[w] === 1'b1 && status[w] == 32'h8000_0002, "R2 invalid", status[w], 32'h8000_0002);
            @(negedge clk);
            chk(busy[w] == 0 && wr_cnt[w] == 0 && host_rd[w] == 0, "R2 no bus", wr_cnt[w] + host_rd[w], 0);
            return;
        end
        k = 0;
        while (!done[w] && k < 40000) begin
            @(negedge clk); k++;
            start[w] = (poke && k == 5);
            idx[w]   = poke ? 2'd3 : idx[w];
        end
        start[w] = 0;
        idle_to = (br >= 1000);
        resp_to = !idle_to && (rl >= 1000);
        bad     = (n > 12) || cor;
        exp_st  = (idle_to || resp_to) ? 32'h8000_0010 : (bad ? 32'h8000_0004 : code);
        if (idle_to)      chk(status[w] == exp_st, "R3 idle timeout", status[w], exp_st);
        else if (resp_to) chk(status[w] == exp_st, "R7 resp timeout", status[w], exp_st);
        else if (bad)     chk(status[w] == exp_st, "R8 checksum", status[w], exp_st);
        else              chk(status[w] == exp_st, "R9 status", status[w], exp_st);
        if (idle_to) begin
            // R3: exactly MAX_POLLS reads, no writes
            chk(host_rd[w] == 1000, "R3 poll count", host_rd[w], 1000);
            chk(wr_cnt[w] == 0, "R3 no write", wr_cnt[w], 0);
        end else begin
            for (int j = 0; j < 16; j++) begin
                // R4: message image
                chk(txmsg[w][j] == exp_tx(api, i, j), "R4 msg word", txmsg[w][j], exp_tx(api, i, j));
                // R6: reply words
                chk(reply[w][j] == (resp_to ? 32'd0 : exp_rep(j, t_head(api, i, 1), n, cor)),
                    "R6 reply", reply[w][j], resp_to ? 32'd0 : exp_rep(j, t_head(api, i, 1), n, cor));
            end
            chk(bell_cnt[w] == 1, "R5 doorbell", bell_cnt[w], 1);
            chk(wr_cnt[w] == 18, "R7 write count", wr_cnt[w], 18);
            chk(last_addr[w] == rel && last_data[w] == 0, "R7 release", {20'b0, last_addr[w]}, {20'b0, rel});
            if (br > 1)
                chk(gap_min[w] >= GAP + 1 && gap_max[w] <= GAP + 6, "R3 poll gap", gap_min[w], GAP + 3);
        end
        @(negedge clk);
        // R1: single done, back to idle, extra start ignored
        chk(busy[w] == 0 && done_cnt[w] == d0 + 1, "R1 one done", done_cnt[w], d0 + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++) begin
            start[w] = 0; idx[w] = 0; clear[w] = 0; done_cnt[w] = 0;
            busy_reads[w] = 0; resp_lat[w] = 0; resp_code[w] = 1; rep_n[w] = 0; corrupt[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int w = 0; w < 2; w++)
            chk(busy[w] == 0 && done[w] == 0 && req[w] == 0, "R1 reset", {31'b0, busy[w]}, 0);

        foreach (start[w]) begin
            for (int i = 0; i < 4; i++) begin
                foreach (rep_n[q]) begin end
                for (int nn = 0; nn < 4; nn++) begin
                    int n = (nn == 0) ? 0 : (nn == 1) ? 1 : (nn == 2) ? 12 : 13;
                    run(w, i, 3, 2, 32'd1, n, 0, 0);
                    run(w, i, 0, 0, 32'h8000_0008, n, 0, 0);
                    run(w, i, 1, 1, 32'd1, n, 1, 0);
                end
            end
        end
        // R1 start while busy ignored
        run(0, 0, 2, 3, 32'd1, 2, 0, 1);
        run(1, 2, 2, 3, 32'd1, 2, 0, 1);
        // R3 idle timeout, R7 response timeout with release
        run(0, 0, 5000, 0, 32'd1, 1, 0, 0);
        run(0, 1, 0, 5000, 32'd1, 1, 0, 0);
        run(1, 0, 0, 5000, 32'd1, 1, 0, 0);
        // R9 error code passed through on a good checksum
        run(1, 1, 0, 0, 32'h8000_0001, 4, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule